// File: doc/BRIEF.md
# Trimmed One-Second Timebase

This block derives a one-second tick from a slow oscillator that reaches it as a single-cycle enable (`tick_en`) in the system clock domain. A prescaler counts enabled cycles and wraps once per second. Each wrap pulses `sec_tick` and advances a free-running seconds count. A modulo-ten counter of those ticks marks a ten-second boundary. At every boundary a signed digital correction is loaded: a programmed multiple of eight oscillator cycles is either added to the prescaler count (the decade runs short) or taken out of it (the decade runs long).

Software sees two registers, selected by `wr_sel`: an 8-bit trim register and a 16-bit control register. The control register holds a run bit, a write-unlock bit and a read-only busy flag. An accepted write to the trim value or to the run bit raises busy for a fixed number of clocks while the new value is handed to the counting logic. Other writes are rejected while busy is high. The new trim and run values only take effect once busy drops. Clearing the run value freezes the prescaler, the decade position, the seconds count and any correction still in progress.

Two small state machines do the work. The write guard has the states `W_OPEN` (writes accepted) and `W_BUSY` (hand-over in progress). It moves from `W_OPEN` to `W_BUSY` on an accepted trim or run write, and from `W_BUSY` back to `W_OPEN` when its countdown expires, which also commits the values. The prescaler has the states `P_STEADY` (one count per enabled cycle) and `P_TRIM` (correction cycles). It moves from `P_STEADY` to `P_TRIM` at a ten-second boundary with a non-zero trim magnitude. It returns to `P_STEADY` when the last correction cycle is applied, or at a boundary where the magnitude is zero.

Top module: `rtc_timebase`

## Requirements
- R1: After `PRE_PERIOD` running enabled cycles the prescaler wraps. `sec_tick` is high for exactly one clock, and `sec_count` increases by one in that same clock and at no other time.
- R2: Trim register (`wr_sel`=0). Bit 7 is the sign: 1 means cycles are added and 0 means cycles are removed. Bits 3:0 are an unsigned magnitude from 0 to 15. Bits 6:4 always read 0.
- R3: With sign 1 and magnitude m, the first m*`TRIM_UNIT` running enabled cycles after a ten-second boundary each advance the prescaler by 2, so that decade is m*8 enabled cycles shorter than 10*`PRE_PERIOD`.
- R4: With sign 0 and magnitude m, the first m*`TRIM_UNIT` running enabled cycles after a ten-second boundary leave the prescaler unchanged, so that decade is m*8 enabled cycles longer.
- R5: A trim write is ignored when control bit 15 (unlock) is 0 or the busy flag is 1.
- R6: Control register (`wr_sel`=1). Bit 0 (run) is written only when unlock is 1 and busy is 0. Bit 3 reads the busy flag and ignores writes.
- R7: Control bits 9:6 and 2:1 are written only when busy is 0. Bit 13 is written only when the stored run bit is 0. Bits 15, 14, 12:10 and 5:4 are always written.
- R8: An accepted trim write, or a control write made while unlocked and not busy, raises busy for `BUSY_CYC` (4) clocks starting in the next clock. The trim and run values in use change in the clock after busy drops.
- R9: While the run value in use is 0, `sec_count`, the prescaler and any pending correction stay frozen whatever `tick_en` does.
- R10: After reset both registers read 0, `sec_count` is 0 and `sec_tick` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-clock enable per oscillator cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects trim, 1 selects control |
| wr_data | input | 16 | Write data (trim uses bits 7:0) |
| trim_q | output | 8 | Trim register readback |
| ctrl_q | output | 16 | Control register readback, busy in bit 3 |
| sec_tick | output | 1 | One-clock pulse per second |
| sec_count | output | SEC_W | Elapsed seconds |

## Verification
The bench measures whole decades in enabled cycles under add, remove and maximum-magnitude trims. A design that applied the correction in the wrong direction, missed the factor of eight or spread it wrongly would show a decade that is off by a visible amount. Writes are fired during busy and while locked, which catches a guard that lets trim or run change mid-transfer or that lengthens or shortens the busy window. Bit 13 is written with run set, and guarded control bits are written during busy, which exposes wrong per-field masks. A stretch with run cleared and `tick_en` still toggling shows whether the seconds count or a pending correction leaks through the freeze.

// File: rtl/rtc_timebase_pkg.sv
package rtc_timebase_pkg;
    typedef enum logic {W_OPEN, W_BUSY} wr_state_t;
    typedef enum logic {P_STEADY, P_TRIM} pre_state_t;

    localparam logic SEL_TRIM = 1'b0;
    localparam logic SEL_CTRL = 1'b1;

    // control fields by write rule
    localparam logic [15:0] CTRL_FREE_M = 16'hDC30; // 15,14,12:10,5:4
    localparam logic [15:0] CTRL_IDLE_M = 16'h03C6; // 9:6,2:1 need !busy
    localparam logic [15:0] CTRL_RUN_M  = 16'h0001; // needs unlock & !busy
    localparam logic [15:0] CTRL_LOCK_M = 16'h2000; // needs run == 0
    localparam int          CTRL_UNLOCK = 15;
    localparam int          CTRL_BUSY   = 3;
endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
    import rtc_timebase_pkg::*;
#(
    parameter int BUSY_CYC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [15:0] wr_data,
    output logic [7:0]  trim_q,
    output logic [15:0] ctrl_q,
    output logic [7:0]  trim_act,
    output logic        run_act
);
    localparam int CNT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC - 1);

    wr_state_t        st, st_n;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       trim_r;
    logic [15:0]      ctrl_r;
    logic             busy, unlocked, trim_ok, run_ok, ctrl_wr;
    logic [15:0]      wmask;

    always_comb begin
        busy     = (st == W_BUSY);
        unlocked = ctrl_r[CTRL_UNLOCK];
        ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
        trim_ok  = wr_en && (wr_sel == SEL_TRIM) && unlocked && !busy;
        run_ok   = ctrl_wr && unlocked && !busy;
        wmask    = CTRL_FREE_M
                 | (busy      ? 16'h0 : CTRL_IDLE_M)
                 | (run_ok    ? CTRL_RUN_M : 16'h0)
                 | (ctrl_r[0] ? 16'h0 : CTRL_LOCK_M);
    end

    always_comb begin
        st_n = st;
        unique case (st)
            W_OPEN: if (trim_ok || run_ok) st_n = W_BUSY;
            W_BUSY: if (cnt == '0)         st_n = W_OPEN;
            default: st_n = W_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= W_OPEN;
            cnt <= '0;
        end else begin
            st <= st_n;
            if (st == W_OPEN) cnt <= CNT_LOAD;
            else if (cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trim_r   <= '0;
            ctrl_r   <= '0;
            trim_act <= '0;
            run_act  <= 1'b0;
        end else begin
            if (trim_ok) trim_r <= {wr_data[7], 3'b000, wr_data[3:0]};
            if (ctrl_wr) ctrl_r <= (ctrl_r & ~wmask) | (wr_data & wmask);
            if (st == W_BUSY && st_n == W_OPEN) begin
                trim_act <= trim_r;
                run_act  <= ctrl_r[0];
            end
        end
    end

    always_comb begin
        trim_q = trim_r;
        ctrl_q = ctrl_r;
        ctrl_q[CTRL_BUSY] = busy;
    end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_timebase_pkg::*;
#(
    parameter int PRE_PERIOD = 32768,
    parameter int DECADE     = 10,
    parameter int TRIM_UNIT  = 8,
    parameter int SEC_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run,
    input  logic [7:0]       trim,
    output logic             sec_tick,
    output logic [SEC_W-1:0] sec_count
);
    localparam int PRE_W = $clog2(PRE_PERIOD);
    localparam int DEC_W = $clog2(DECADE);
    localparam int ADJ_W = $clog2(15 * TRIM_UNIT + 1);
    localparam logic [PRE_W:0]   PERIOD_V = (PRE_W+1)'(PRE_PERIOD);
    localparam logic [DEC_W-1:0] DEC_LAST = DEC_W'(DECADE - 1);
    localparam logic [ADJ_W-1:0] UNIT_V   = ADJ_W'(TRIM_UNIT);

    pre_state_t       st, st_n;
    logic [PRE_W-1:0] pre;
    logic [DEC_W-1:0] dec;
    logic [ADJ_W-1:0] adj_left, load_amt;
    logic             adj_add;
    logic             advance, wrap, boundary;
    logic [1:0]       step;
    logic [PRE_W:0]   nxt;

    always_comb begin
        advance = tick_en && run;
        if (st == P_TRIM) step = adj_add ? 2'd2 : 2'd0;
        else              step = 2'd1;
        nxt      = {1'b0, pre} + (PRE_W+1)'(step);
        wrap     = (nxt >= PERIOD_V);
        boundary = advance && wrap && (dec == DEC_LAST);
        load_amt = ADJ_W'(trim[3:0]) * UNIT_V;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            P_STEADY: if (boundary && load_amt != '0) st_n = P_TRIM;
            P_TRIM: begin
                if (boundary)                               st_n = (load_amt != '0) ? P_TRIM : P_STEADY;
                else if (advance && adj_left == ADJ_W'(1)) st_n = P_STEADY;
            end
            default: st_n = P_STEADY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= P_STEADY;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre       <= '0;
            dec       <= '0;
            adj_left  <= '0;
            adj_add   <= 1'b0;
            sec_tick  <= 1'b0;
            sec_count <= '0;
        end else begin
            sec_tick <= advance && wrap;
            if (advance) begin
                pre <= wrap ? PRE_W'(nxt - PERIOD_V) : PRE_W'(nxt);
                if (wrap) begin
                    sec_count <= sec_count + 1'b1;
                    dec       <= (dec == DEC_LAST) ? '0 : dec + 1'b1;
                end
                if (boundary) begin
                    adj_left <= load_amt;
                    adj_add  <= trim[7];
                end else if (st == P_TRIM) begin
                    adj_left <= adj_left - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtc_timebase_pkg::*;
#(
    parameter int PRE_PERIOD = 32768,
    parameter int DECADE     = 10,
    parameter int TRIM_UNIT  = 8,
    parameter int BUSY_CYC   = 4,
    parameter int SEC_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [15:0]      wr_data,
    output logic [7:0]       trim_q,
    output logic [15:0]      ctrl_q,
    output logic             sec_tick,
    output logic [SEC_W-1:0] sec_count
);
    logic [7:0] trim_act;
    logic       run_act;

    rtc_regs #(.BUSY_CYC(BUSY_CYC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .trim_q   (trim_q),
        .ctrl_q   (ctrl_q),
        .trim_act (trim_act),
        .run_act  (run_act)
    );

    rtc_prescaler #(
        .PRE_PERIOD (PRE_PERIOD),
        .DECADE     (DECADE),
        .TRIM_UNIT  (TRIM_UNIT),
        .SEC_W      (SEC_W)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .run       (run_act),
        .trim      (trim_act),
        .sec_tick  (sec_tick),
        .sec_count (sec_count)
    );
endmodule

// File: rtl/rtc_timebase_chk.sv
module rtc_timebase_chk #(
    parameter int SEC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       trim_q,
    input logic [15:0]      ctrl_q,
    input logic             sec_tick,
    input logic [SEC_W-1:0] sec_count,
    input logic             run_act
);
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> sec_count == $past(sec_count) + 1'b1);  // R1
    AST_SEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |-> $stable(sec_count));  // R1
    AST_TRIM_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[3] |=> $stable(trim_q));  // R5
    AST_TRIM_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[15] |=> $stable(trim_q));  // R5
    AST_RUN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[15] || ctrl_q[3]) |=> $stable(ctrl_q[0]));  // R6
    AST_IDLE_BITS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[3] |=> ($stable(ctrl_q[9:6]) && $stable(ctrl_q[2:1])));  // R7
    AST_BIT13_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[0] |=> $stable(ctrl_q[13]));  // R7
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !run_act |=> (!sec_tick && $stable(sec_count)));  // R9
endmodule

bind rtc_timebase rtc_timebase_chk #(.SEC_W(SEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trim_q    (trim_q),
    .ctrl_q    (ctrl_q),
    .sec_tick  (sec_tick),
    .sec_count (sec_count),
    .run_act   (run_act)
);

// File: tb/rtc_timebase_tb.sv
`timescale 1ns/1ps
module rtc_timebase_tb;
    localparam int P = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  trim_q;
    logic [15:0] ctrl_q;
    logic        sec_tick;
    logic [31:0] sec_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rtc_timebase #(.PRE_PERIOD(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .trim_q(trim_q),
        .ctrl_q(ctrl_q), .sec_tick(sec_tick), .sec_count(sec_count)
    );

    // behavioural reference
    logic [7:0]  m_trim, m_trim_use;
    logic [15:0] m_ctrl;
    int m_busy_left, m_pre, m_dec, m_sec, m_adj_left;
    bit m_run_use, m_adj_add, m_tick;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_trim = 0; m_trim_use = 0; m_ctrl = 0; m_busy_left = 0;
            m_pre = 0; m_dec = 0; m_sec = 0; m_adj_left = 0;
            m_run_use = 0; m_adj_add = 0; m_tick = 0;
        end else begin
            bit was_busy;
            bit was_unlocked;
            bit started;
            m_tick = 0;
            if (tick_en && m_run_use) begin
                int inc;
                inc = 1;
                if (m_adj_left > 0) begin
                    inc = m_adj_add ? 2 : 0;
                    m_adj_left--;
                end
                m_pre += inc;
                if (m_pre >= P) begin
                    m_pre -= P;
                    m_tick = 1;
                    m_sec++;
                    if (m_dec == 9) begin
                        m_dec = 0;
                        m_adj_left = m_trim_use[3:0] * 8;
                        m_adj_add = m_trim_use[7];
                    end else m_dec++;
                end
            end
            was_busy = (m_busy_left > 0);
            was_unlocked = m_ctrl[15];
            started = 0;
            if (wr_en && !wr_sel && was_unlocked && !was_busy) begin
                m_trim = {wr_data[7], 3'b000, wr_data[3:0]};
                started = 1;
            end
            if (wr_en && wr_sel) begin
                logic [15:0] nv;
                nv = m_ctrl;
                nv[15] = wr_data[15]; nv[14] = wr_data[14];
                nv[12:10] = wr_data[12:10]; nv[5:4] = wr_data[5:4];
                if (!was_busy) begin
                    nv[9:6] = wr_data[9:6];
                    nv[2:1] = wr_data[2:1];
                end
                if (was_unlocked && !was_busy) begin
                    nv[0] = wr_data[0];
                    started = 1;
                end
                if (!m_ctrl[0]) nv[13] = wr_data[13];
                m_ctrl = nv;
            end
            if (was_busy) begin
                m_busy_left--;
                if (m_busy_left == 0) begin
                    m_trim_use = m_trim;
                    m_run_use = m_ctrl[0];
                end
            end else if (started) m_busy_left = 4;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [15:0] exp_ctrl;
            exp_ctrl = m_ctrl | ((m_busy_left > 0) ? 16'h0008 : 16'h0000);
            chk("R2", "trim_q", trim_q, m_trim);
            chk("R7", "ctrl_q", ctrl_q, exp_ctrl);
            chk("R1", "sec_count", sec_count, m_sec);
            chk("R1", "sec_tick", sec_tick, m_tick);
        end
    end

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // clocks between two consecutive ten-second boundaries (tick_en held high)
    task automatic decade_len(output int len);
        len = 0;
        do @(negedge clk); while (!(sec_tick && sec_count % 10 == 0));
        do begin
            @(negedge clk);
            len++;
        end while (!(sec_tick && sec_count % 10 == 0));
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int len;
        int frozen_sec;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10", "trim reset", trim_q, 0);
        chk("R10", "ctrl reset", ctrl_q, 0);
        chk("R10", "sec reset", sec_count, 0);

        // R5 locked: trim write ignored
        wr(1'b0, 16'h0085);
        chk("R5", "trim while locked", trim_q, 8'h00);
        // R6 run not writable while locked; unlock does not raise busy
        wr(1'b1, 16'h8001);
        chk("R6", "run while locked", ctrl_q, 16'h8000);

        // R2 reserved bits read zero; R8 busy raised
        wr(1'b0, 16'h00F5);
        chk("R2", "reserved bits", trim_q, 8'h85);
        chk("R8", "busy after trim write", ctrl_q[3], 1);
        wr(1'b0, 16'h0003);
        chk("R5", "trim while busy", trim_q, 8'h85);
        idle(4);
        chk("R8", "busy cleared", ctrl_q[3], 0);

        // run on, then guarded bits during busy
        wr(1'b1, 16'h8001);
        wr(1'b1, 16'h83C6);
        chk("R7", "idle bits during busy", ctrl_q & 16'hFFF7, 16'h8001);
        chk("R6", "busy bit read-only", ctrl_q[3], 1);
        idle(4);
        wr(1'b1, 16'hA3C7);
        chk("R7", "bit13 locked by run", ctrl_q[13], 0);
        chk("R7", "idle bits when free", ctrl_q[9:6], 4'hF);
        idle(5);
        wr(1'b1, 16'h8001);
        idle(5);

        // R3 insertion, magnitude 5
        tick_en = 1'b1;
        decade_len(len);
        decade_len(len);
        chk("R3", "decade with +5", len, 10 * P - 40);

        // R4 removal, magnitude 7
        wr(1'b0, 16'h0007);
        idle(5);
        decade_len(len);
        decade_len(len);
        chk("R4", "decade with -7", len, 10 * P + 56);

        // R3 maximum insertion
        wr(1'b0, 16'h008F);
        idle(5);
        decade_len(len);
        decade_len(len);
        chk("R3", "decade with +15", len, 10 * P - 120);

        // sparse enable pattern
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            tick_en = (i % 3 == 0);
        end
        tick_en = 1'b1;

        // R9 freeze
        wr(1'b1, 16'h8000);
        idle(5);
        frozen_sec = sec_count;
        idle(800);
        chk("R9", "frozen seconds", sec_count, frozen_sec);
        wr(1'b1, 16'h8001);
        idle(1500);
        chk("R9", "resumed seconds", sec_count > frozen_sec, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule